// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block counts down from a programmable timeout, moving one step per tick pulse from an external prescaler, and requires software to kick it before it runs out. Software talks to it over a small register bus with four word addresses: a kick/count port, a timeout value, a control word and a status word. The timer comes out of reset halted. Software clears the halt bit to start it and refreshes it by writing to the kick port.

The first expiry is a warning. It latches a timeout flag, reloads the counter and, if enabled, drives an interrupt. If the counter runs out again while that flag is still set, the block latches a second-timeout flag and pulses a reset request for one clock. A no-reboot control bit turns that request into a boot-status flag instead, and a hardware strap can force that bit on. Status bits are write-one-to-clear. The second-timeout flag sits in a power-on reset domain, so after the system reset that the watchdog itself requests, software can still read it and tell that the restart came from a watchdog timeout.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the control word reads 1 (halted, interrupt disabled, no-reboot clear when the strap is low), the count and timeout read the reset timeout value, status reads 0, and both irq_o and reset_req_o are low.
- R2: When control bit 0 (halt) is clear, each cycle with tick_i high decrements the count by one. While halt is set, ticks leave the count unchanged.
- R3: A write to address 0 whose data bits [4:0] are not all zero loads the count from the stored timeout value. A write to address 0 with those bits zero has no effect.
- R4: A write to address 1 stores the timeout value, clamped to at least TMO_MIN and at most 2^TW-1. The count does not change until the next reload.
- R5: A tick that arrives while the running count is 1 is an expiry and reloads the count. If status bit 0 was clear, the expiry sets it. irq_o equals status bit 0 AND control bit 1 (interrupt enable).
- R6: An expiry while status bit 0 is already set sets status bit 1 (second timeout). reset_req_o goes high for exactly one cycle, starting the cycle after that expiry.
- R7: When control bit 2 (no-reboot) reads 1, a second expiry sets status bit 2 (boot) and leaves reset_req_o low. While strap_nr_i is high, control bit 2 reads 1 even after a write of 0 to it.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: A single status write with both bit 1 and bit 2 set clears only bit 1. Bit 2 needs a write with bit 1 clear.
- R10: Status bit 1 survives rst_ni and is cleared only by por_ni (or by R8).
- R11: A kick in the same cycle as an expiring tick reloads the count and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async system reset |
| por_ni | input | 1 | Active-low async power-on reset; also clears the second-timeout flag |
| tick_i | input | 1 | Prescaler tick, one-cycle pulse |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 kick/count, 1 timeout, 2 control, 3 status |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for bus_addr_i (combinational) |
| strap_nr_i | input | 1 | Hardware strap forcing no-reboot |
| irq_o | output | 1 | First-stage interrupt request |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
A corrupted count shows up on the next read of address 0. If nobody reads it, it shows up as an expiry that lands early or late against the tick count. A lost or spurious timeout flag appears at once on irq_o when interrupts are enabled, and otherwise as a reset request or boot flag one timeout period later. The bench runs a behavioural model next to the block and compares irq_o, reset_req_o and the selected read word every cycle, so a divergence is caught in the cycle it reaches a port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    A_KICK = 2'd0,
    A_TMO  = 2'd1,
    A_CTRL = 2'd2,
    A_STAT = 2'd3
  } wdog_addr_e;

  localparam int C_HALT = 0;
  localparam int C_IEN  = 1;
  localparam int C_NR   = 2;

  localparam int S_TMO  = 0;
  localparam int S_SEC  = 1;
  localparam int S_BOOT = 2;
  localparam int N_STS  = 3;

  localparam int KICK_BITS = 5;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TMO_MIN = 4,
  parameter int TMO_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              strap_i,
  input  logic [TW-1:0]     count_i,
  input  logic [N_STS-1:0]  sts_i,
  output logic [DW-1:0]     rdata_o,
  output logic              kick_o,
  output logic [N_STS-1:0]  clr_o,
  output logic              halt_o,
  output logic              ien_o,
  output logic              nr_eff_o,
  output logic [TW-1:0]     tmo_val_o
);
  localparam int MAX_I = (1 << TW) - 1;

  wdog_addr_e  addr;
  logic        wr_tmo, wr_ctrl, wr_stat;
  logic [TW-1:0] tmo_q, tmo_clamped;
  logic        halt_q, ien_q, nr_q;

  assign addr    = wdog_addr_e'(addr_i);
  assign wr_tmo  = we_i && (addr == A_TMO);
  assign wr_ctrl = we_i && (addr == A_CTRL);
  assign wr_stat = we_i && (addr == A_STAT);
  assign kick_o  = we_i && (addr == A_KICK) && (|wdata_i[KICK_BITS-1:0]);
  assign clr_o   = wr_stat ? wdata_i[N_STS-1:0] : '0;

  // clamp; upper bound only exists when the field is narrower than the bus
  generate
    if (TW < DW) begin : g_clamp_hi
      always_comb begin
        if (wdata_i < DW'(TMO_MIN))    tmo_clamped = TW'(TMO_MIN);
        else if (wdata_i > DW'(MAX_I)) tmo_clamped = TW'(MAX_I);
        else                           tmo_clamped = wdata_i[TW-1:0];
      end
    end else begin : g_clamp_lo
      always_comb begin
        if (wdata_i < DW'(TMO_MIN)) tmo_clamped = TW'(TMO_MIN);
        else                        tmo_clamped = wdata_i[TW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= TW'(TMO_RST);
      halt_q <= 1'b1;
      ien_q  <= 1'b0;
      nr_q   <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q <= tmo_clamped;
      if (wr_ctrl) begin
        halt_q <= wdata_i[C_HALT];
        ien_q  <= wdata_i[C_IEN];
        nr_q   <= wdata_i[C_NR];
      end
    end
  end

  assign halt_o    = halt_q;
  assign ien_o     = ien_q;
  assign nr_eff_o  = nr_q | strap_i;
  assign tmo_val_o = tmo_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_KICK: rdata_o[TW-1:0] = count_i;
      A_TMO:  rdata_o[TW-1:0] = tmo_q;
      A_CTRL: begin
        rdata_o[C_HALT] = halt_q;
        rdata_o[C_IEN]  = ien_q;
        rdata_o[C_NR]   = nr_eff_o;
      end
      A_STAT: rdata_o[N_STS-1:0] = sts_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TW      = 16,
  parameter int TMO_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          kick_i,
  input  logic [TW-1:0] tmo_val_i,
  output logic [TW-1:0] count_o,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic          step;

  assign step     = tick_i && !halt_i;
  // kick has priority over an expiring tick
  assign expire_o = step && (cnt_q == TW'(1)) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= TW'(TMO_RST);
    else if (kick_i)               cnt_q <= tmo_val_i;
    else if (step) begin
      if (cnt_q == TW'(1))         cnt_q <= tmo_val_i;
      else                         cnt_q <= cnt_q - TW'(1);
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             expire_i,
  input  logic [N_STS-1:0] clr_i,
  input  logic             nr_eff_i,
  input  logic             ien_i,
  output logic [N_STS-1:0] sts_o,
  output logic             irq_o,
  output logic             reset_req_o
);
  logic tmo_q, sec_q, boot_q, req_q;
  logic first_exp, second_exp, clr_boot;

  assign first_exp  = expire_i && !tmo_q;
  assign second_exp = expire_i && tmo_q;
  // boot flag clears only on a write that leaves the second-timeout bit alone
  assign clr_boot   = clr_i[S_BOOT] && !clr_i[S_SEC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= 1'b0;
      boot_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      tmo_q  <= first_exp | (tmo_q & ~clr_i[S_TMO]);
      boot_q <= (second_exp & nr_eff_i) | (boot_q & ~clr_boot);
      req_q  <= second_exp & ~nr_eff_i;
    end
  end

  // power-on domain: survives the reset this block requests
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) sec_q <= 1'b0;
    else         sec_q <= second_exp | (sec_q & ~clr_i[S_SEC]);
  end

  always_comb begin
    sts_o         = '0;
    sts_o[S_TMO]  = tmo_q;
    sts_o[S_SEC]  = sec_q;
    sts_o[S_BOOT] = boot_q;
  end

  assign irq_o       = tmo_q & ien_i;
  assign reset_req_o = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TMO_MIN = 4,
  parameter int TMO_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          tick_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          strap_nr_i,
  output logic          irq_o,
  output logic          reset_req_o
);
  // rst_ni is expected to be asserted whenever por_ni is
  logic [TW-1:0]    count, tmo_val;
  logic [N_STS-1:0] sts, clr;
  logic             kick, halt, ien, nr_eff, expire;

  wdog_regs #(
    .DW(DW), .TW(TW), .TMO_MIN(TMO_MIN), .TMO_RST(TMO_RST)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .strap_i   (strap_nr_i),
    .count_i   (count),
    .sts_i     (sts),
    .rdata_o   (bus_rdata_o),
    .kick_o    (kick),
    .clr_o     (clr),
    .halt_o    (halt),
    .ien_o     (ien),
    .nr_eff_o  (nr_eff),
    .tmo_val_o (tmo_val)
  );

  wdog_counter #(.TW(TW), .TMO_RST(TMO_RST)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .halt_i    (halt),
    .kick_i    (kick),
    .tmo_val_i (tmo_val),
    .count_o   (count),
    .expire_o  (expire)
  );

  wdog_status u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_ni      (por_ni),
    .expire_i    (expire),
    .clr_i       (clr),
    .nr_eff_i    (nr_eff),
    .ien_i       (ien),
    .sts_o       (sts),
    .irq_o       (irq_o),
    .reset_req_o (reset_req_o)
  );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          strap_nr_i,
  input logic          halt,
  input logic          kick,
  input logic [TW-1:0] count,
  input logic [TW-1:0] tmo_val,
  input logic          nr_eff,
  input logic [2:0]    sts,
  input logic          irq_o,
  input logic          reset_req_o
);
  p_halt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !kick) |=> $stable(count));

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt && !kick && (count > TW'(1))) |=> (count == $past(count) - TW'(1)));

  p_kick_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (count == $past(tmo_val)));

  p_irq_needs_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts[0]);

  p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);

  p_req_sets_sec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> sts[1]);

  p_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> !$past(nr_eff));

  p_strap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_nr_i |-> nr_eff);
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .strap_nr_i  (strap_nr_i),
  .halt        (halt),
  .kick        (kick),
  .count       (count),
  .tmo_val     (tmo_val),
  .nr_eff      (nr_eff),
  .sts         (sts),
  .irq_o       (irq_o),
  .reset_req_o (reset_req_o)
);

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;
  localparam int DW = 16, TW = 12, TMO_MIN = 4, TMO_RST = 8;

  logic clk = 0, rst_n = 0, por_n = 0, tick = 0, we = 0, strap = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic irq, req;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state
  int m_cnt, m_tmo, m_halt, m_ien, m_nr, m_st0, m_st2, m_boot, m_req;

  always #4 clk = ~clk;

  wdog_two_stage #(.DW(DW), .TW(TW), .TMO_MIN(TMO_MIN), .TMO_RST(TMO_RST)) u_wdog_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .strap_nr_i(strap), .irq_o(irq), .reset_req_o(req)
  );

  always @(posedge clk or negedge rst_n or negedge por_n) begin : mdl
    int nre, kick, ex, fst, snd, c0, c1, c2, v;
    if (!por_n || !rst_n) begin
      m_cnt = TMO_RST; m_tmo = TMO_RST; m_halt = 1; m_ien = 0; m_nr = 0;
      m_st0 = 0; m_boot = 0; m_req = 0;
      if (!por_n) m_st2 = 0;
    end else begin
      nre  = (m_nr != 0 || strap) ? 1 : 0;
      kick = (we && addr == 0 && wdata[4:0] != 0) ? 1 : 0;
      ex   = (tick && !m_halt && m_cnt == 1 && !kick) ? 1 : 0;
      fst  = ex && !m_st0;
      snd  = ex && m_st0;
      c0 = 0; c1 = 0; c2 = 0;
      if (we && addr == 3) begin c0 = wdata[0]; c1 = wdata[1]; c2 = wdata[2]; end
      if (kick) m_cnt = m_tmo;
      else if (tick && !m_halt) m_cnt = (m_cnt == 1) ? m_tmo : m_cnt - 1;
      m_st0  = (fst || (m_st0 && !c0)) ? 1 : 0;
      m_st2  = (snd || (m_st2 && !c1)) ? 1 : 0;
      m_boot = ((snd && nre) || (m_boot && !(c2 && !c1))) ? 1 : 0;
      m_req  = (snd && !nre) ? 1 : 0;
      if (we && addr == 1) begin
        v = int'(wdata);
        if (v < TMO_MIN) v = TMO_MIN;
        if (v > (1 << TW) - 1) v = (1 << TW) - 1;
        m_tmo = v;
      end
      if (we && addr == 2) begin m_halt = wdata[0]; m_ien = wdata[1]; m_nr = wdata[2]; end
    end
  end

  function automatic int mrd(input int a);
    case (a)
      0: return m_cnt;
      1: return m_tmo;
      2: return m_halt | (m_ien << 1) | (((m_nr != 0 || strap) ? 1 : 0) << 2);
      default: return m_st0 | (m_st2 << 1) | (m_boot << 2);
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk({cur_req, " irq"}, int'(irq), (m_st0 != 0 && m_ien != 0) ? 1 : 0);
    chk({cur_req, " reset_req"}, int'(req), m_req);
    chk({cur_req, " rdata"}, int'(rdata), mrd(int'(addr)));
  endtask

  task automatic step(input bit w, input int a, input int d, input bit tk);
    @(negedge clk);
    cmp();
    we = w; addr = a[1:0]; wdata = d[DW-1:0]; tick = tk;
  endtask

  task automatic wr(input int a, input int d);
    step(1, a, d, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  task automatic rd(input int a, input int e, input string tag);
    @(negedge clk);
    cmp();
    we = 0; addr = a[1:0]; wdata = 0; tick = 0;
    #1;
    chk(tag, int'(rdata), e);
  endtask

  task automatic req_at_edge(input int e, input string tag);
    @(posedge clk);
    #1;
    chk(tag, int'(req), e);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;

    // R1 reset state
    cur_req = "R1";
    rd(2, 1, "R1 ctrl");
    rd(0, TMO_RST, "R1 count");
    rd(1, TMO_RST, "R1 timeout");
    rd(3, 0, "R1 status");
    chk("R1 irq", int'(irq), 0);
    chk("R1 reset_req", int'(req), 0);

    // R2 halted ticks ignored
    cur_req = "R2";
    ticks(3);
    rd(0, 8, "R2 halted");

    // R4 timeout write does not restart count
    cur_req = "R4";
    wr(1, 20);
    rd(0, 8, "R4 no restart");
    rd(1, 20, "R4 stored");

    // R2 running decrement
    cur_req = "R2";
    wr(2, 0);
    ticks(3);
    rd(0, 5, "R2 decrement");

    // R3 kick
    cur_req = "R3";
    wr(0, 32'h20);
    rd(0, 5, "R3 zero low bits ignored");
    wr(0, 1);
    rd(0, 20, "R3 reload");

    // R4 clamps
    cur_req = "R4";
    wr(1, 2);
    rd(1, TMO_MIN, "R4 min clamp");
    wr(1, 16'hFFFF);
    rd(1, (1 << TW) - 1, "R4 max clamp");
    rd(0, 20, "R4 count kept");
    wr(1, 6);
    wr(0, 5'h1F);

    // R5 first expiry with interrupt
    cur_req = "R5";
    wr(2, 2);
    ticks(6);
    rd(3, 1, "R5 timeout flag");
    chk("R5 irq", int'(irq), 1);
    rd(0, 6, "R5 reload on expiry");

    // R8 write-one-to-clear
    cur_req = "R8";
    wr(3, 0);
    rd(3, 1, "R8 zero write");
    wr(3, 1);
    rd(3, 0, "R8 one write");
    chk("R8 irq drop", int'(irq), 0);

    // R11 kick beats expiry
    cur_req = "R11";
    ticks(5);
    rd(0, 1, "R11 at one");
    step(1, 0, 1, 1);
    rd(3, 0, "R11 no status");
    rd(0, 6, "R11 reloaded");

    // R6 second expiry -> reset request pulse
    cur_req = "R6";
    ticks(12);
    req_at_edge(1, "R6 pulse high");
    rd(3, 3, "R6 flags");
    req_at_edge(0, "R6 pulse one cycle");

    // R10 second-timeout flag survives system reset
    cur_req = "R10";
    @(negedge clk);
    cmp();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(3, 2, "R10 sticky flag");
    rd(2, 1, "R10 halted again");
    rd(0, TMO_RST, "R10 count reset");
    @(negedge clk);
    por_n = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1; rst_n = 1;
    rd(3, 0, "R10 cleared by por");

    // R7 no-reboot: boot flag, no request
    cur_req = "R7";
    wr(2, 6);
    ticks(8);
    rd(3, 1, "R7 first expiry");
    ticks(8);
    req_at_edge(0, "R7 inhibited");
    rd(3, 7, "R7 boot flag");

    // R9 separate clears
    cur_req = "R9";
    wr(3, 6);
    rd(3, 5, "R9 only second cleared");
    wr(3, 4);
    rd(3, 1, "R9 boot cleared alone");
    wr(3, 1);
    rd(3, 0, "R9 all clear");

    // R7 strap lock
    cur_req = "R7";
    @(negedge clk);
    cmp();
    strap = 1;
    wr(2, 2);
    rd(2, 6, "R7 strap locks no-reboot");

    done = 1;
    summary();
    $finish;
  end
endmodule